// File: doc/BRIEF.md
# Board Control Register Block

This peripheral sits on a plain 32-bit register bus. It offers a small set of board-level controls and identity words. A host reads a fixed identity constant and a constant reference-clock frequency. It drives a bank of LEDs through a read/write register and reads back the board switches. The switch inputs are brought into the clock domain by a synchronizer before they are visible.

A write-only command word lets software ask for a whole-system reset. Only one magic value triggers the request, which leaves the block as a one-cycle pulse. Acting on that request belongs to a reset controller outside this block.

The decoded window covers 64 KiB. Only word-aligned accesses are decoded. Read data is registered, so it appears one cycle after the read strobe.

Top module: `board_ctl_regs`

## Requirements
- R1: A read at byte offset 0x0 returns 0x09272011.
- R2: A read at byte offset 0x4 returns the reference frequency 10000000 decimal (0x00989680).
- R3: A write at offset 0x8 stores the low LED_W data bits, which drive `ledOut` from the next cycle; a read at 0x8 returns them zero-extended.
- R4: `swIn` passes through two synchronizer flops and is then captured into the switch register every cycle. A value applied before clock edge k is held in the switch register after edge k+2. A read at offset 0xC returns it zero-extended.
- R5: Writes to offset 0xC have no effect on the value read back there.
- R6: A write of exactly 0x0000DEAD to offset 0x10 drives `sysRstReq` high for exactly the cycle after the write. Any other value written there leaves `sysRstReq` low.
- R7: Reads of offset 0x10, of undecoded offsets and of any address with bits [1:0] non-zero return zero. Writes to such addresses change nothing.
- R8: While `rstN` is low, `ledOut`, the switch register, `busRdData` and `sysRstReq` are all zero.
- R9: `busRdData` holds the addressed value in the cycle after a read strobe, and is zero in any cycle that follows a cycle without a read strobe.
- R10: When a read and a write to offset 0x8 occur in the same cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address within the window |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Registered read data |
| ledOut | output | LED_W | LED drive bits |
| swIn | input | SW_W | Asynchronous switch inputs |
| sysRstReq | output | 1 | One-cycle system reset request |

## Verification
A read and a write can land in the same cycle. The bench provokes this by driving both strobes together at the LED offset. The reference model updates its LED copy only after it has formed the expected read word, so a read that returns the newly written value is flagged. A second overlap is covered as well: a switch change while a read of the switch offset is already in flight. The model's two-stage pipeline judges which switch value that read must return.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam logic [31:0] ID_WORD    = 32'h0927_2011;
  localparam logic [31:0] FREQ_WORD  = 32'd10_000_000;
  localparam logic [31:0] MAGIC_WORD = 32'h0000_DEAD;

  // word indices (byte offset / 4)
  localparam int IDX_ID   = 0;
  localparam int IDX_FREQ = 1;
  localparam int IDX_LED  = 2;
  localparam int IDX_SW   = 3;
  localparam int IDX_CMD  = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ID,
    SEL_FREQ,
    SEL_LED,
    SEL_SW
  } rdSel_e;

  typedef struct packed {
    logic   rdEn;
    rdSel_e rdSel;
    logic   ledWr;
    logic   cmdWr;
  } strobes_t;
endpackage

// File: rtl/bcr_ctrl.sv
module bcr_ctrl
  import bcr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output strobes_t          strb
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    strb = '0;
    strb.rdEn  = busRdEn;
    strb.rdSel = SEL_NONE;
    if (aligned) begin
      case (wordIdx)
        IDX_W'(IDX_ID):   strb.rdSel = SEL_ID;
        IDX_W'(IDX_FREQ): strb.rdSel = SEL_FREQ;
        IDX_W'(IDX_LED):  strb.rdSel = SEL_LED;
        IDX_W'(IDX_SW):   strb.rdSel = SEL_SW;
        default:          strb.rdSel = SEL_NONE;
      endcase
      strb.ledWr = busWrEn && (wordIdx == IDX_W'(IDX_LED));
      strb.cmdWr = busWrEn && (wordIdx == IDX_W'(IDX_CMD));
    end
  end
endmodule

// File: rtl/bcr_datapath.sv
module bcr_datapath
  import bcr_pkg::*;
#(
  parameter int LED_W       = 16,
  parameter int SW_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic [31:0]      wrData,
  input  logic [SW_W-1:0]  swIn,
  output logic [31:0]      rdData,
  output logic [LED_W-1:0] ledOut,
  output logic             sysRstReq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SW_W-1:0]  syncQ [SYNC_STAGES];
  logic [SW_W-1:0]  swReg;
  logic [LED_W-1:0] ledReg;
  logic [31:0]      rdMux;

  always_comb begin
    case (strb.rdSel)
      SEL_ID:   rdMux = ID_WORD;
      SEL_FREQ: rdMux = FREQ_WORD;
      SEL_LED:  rdMux = 32'(ledReg);
      SEL_SW:   rdMux = 32'(swReg);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
      swReg     <= '0;
      ledReg    <= '0;
      rdData    <= '0;
      sysRstReq <= 1'b0;
    end else begin
      syncQ[0] <= swIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
      swReg <= syncQ[LAST];
      if (strb.ledWr) ledReg <= wrData[LED_W-1:0];
      sysRstReq <= strb.cmdWr && (wrData == MAGIC_WORD);
      rdData    <= strb.rdEn ? rdMux : '0;
    end
  end

  assign ledOut = ledReg;
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
  import bcr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LED_W  = 16,
  parameter int SW_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic              busRdEn,
  output logic [31:0]       busRdData,
  output logic [LED_W-1:0]  ledOut,
  input  logic [SW_W-1:0]   swIn,
  output logic              sysRstReq
);
  strobes_t strb;

  bcr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strb    (strb)
  );

  bcr_datapath #(.LED_W(LED_W), .SW_W(SW_W), .SYNC_STAGES(2)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (busWrData),
    .swIn      (swIn),
    .rdData    (busRdData),
    .ledOut    (ledOut),
    .sysRstReq (sysRstReq)
  );
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker
  import bcr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LED_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [31:0]       busWrData,
  input logic              busRdEn,
  input logic [31:0]       busRdData,
  input logic [LED_W-1:0]  ledOut,
  input logic              sysRstReq
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    (armed && sysRstReq) |-> $past(busWrEn && busAddr == ADDR_W'(16'h10) && busWrData == MAGIC_WORD));

  a_r6_pulse_fires: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(16'h10) && busWrData == MAGIC_WORD) |=> sysRstReq);

  a_r3_led_load: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(16'h8)) |=> ledOut == $past(busWrData[LED_W-1:0]));

  a_r7_led_hold: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(busWrEn && busAddr == ADDR_W'(16'h8))) |-> $stable(ledOut));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(busRdEn)) |-> busRdData == 32'h0);

  a_r1_id_read: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(16'h0)) |=> busRdData == ID_WORD);

  a_r8_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (ledOut == '0 && sysRstReq == 1'b0 && busRdData == 32'h0));
endmodule

bind board_ctl_regs bcr_checker #(.ADDR_W(ADDR_W), .LED_W(LED_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdEn   (busRdEn),
  .busRdData (busRdData),
  .ledOut    (ledOut),
  .sysRstReq (sysRstReq)
);

// File: tb/sim_board_ctl_regs.sv
`timescale 1ns/1ps
module sim_board_ctl_regs;
  localparam int ADDR_W = 16;
  localparam int LED_W  = 16;
  localparam int SW_W   = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [31:0]       busWrData = '0;
  logic              busRdEn = 1'b0;
  logic [31:0]       busRdData;
  logic [LED_W-1:0]  ledOut;
  logic [SW_W-1:0]   swIn = '0;
  logic              sysRstReq;

  int checks = 0;
  int errors = 0;
  string curReq = "R8";
  bit done = 1'b0;

  always #4 clk = ~clk;

  board_ctl_regs #(.ADDR_W(ADDR_W), .LED_W(LED_W), .SW_W(SW_W)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .ledOut(ledOut), .swIn(swIn), .sysRstReq(sysRstReq)
  );

  // behavioural reference model
  logic [31:0] expRd;
  logic [31:0] expLed;
  logic        expRst;
  logic [31:0] swPipe [$];

  function automatic logic [31:0] lookup(input logic [ADDR_W-1:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (int'(a))
      0:       return 32'h0927_2011;
      4:       return 32'd10000000;
      8:       return expLed;
      12:      return swPipe[2];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expRd = 0; expLed = 0; expRst = 0;
      swPipe = '{32'h0, 32'h0, 32'h0};
    end else begin
      expRst = busWrEn && busAddr == 16'h10 && busWrData == 32'h0000DEAD;
      expRd  = busRdEn ? lookup(busAddr) : 32'h0;
      if (busWrEn && busAddr == 16'h8) expLed = {16'h0, busWrData[LED_W-1:0]};
      swPipe.push_front({24'h0, swIn});
      void'(swPipe.pop_back());
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (busRdData !== expRd) begin
        errors++;
        $display("FAIL %s busRdData got %h exp %h", curReq, busRdData, expRd);
      end
      checks++;
      if (32'(ledOut) !== expLed) begin
        errors++;
        $display("FAIL %s ledOut got %h exp %h", curReq, ledOut, expLed);
      end
      checks++;
      if (sysRstReq !== expRst) begin
        errors++;
        $display("FAIL %s sysRstReq got %b exp %b", curReq, sysRstReq, expRst);
      end
    end
  end

  task automatic cyc(input bit we, input bit re, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    busWrEn = we; busRdEn = re; busAddr = a; busWrData = d;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 16'h0, 32'h0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset state, with switches active during reset
    curReq = "R8";
    swIn = 8'hA5;
    repeat (4) @(negedge clk);
    #1 rstN = 1'b1;
    idle(1);
    curReq = "R1"; cyc(0, 1, 16'h0, 0);
    curReq = "R2"; cyc(0, 1, 16'h4, 0);
    curReq = "R9"; idle(2);
    curReq = "R3"; cyc(1, 0, 16'h8, 32'h1234_5678); cyc(0, 1, 16'h8, 0);
    cyc(1, 1, 16'h8, 32'hFFFF_0001);
    curReq = "R10"; cyc(1, 1, 16'h8, 32'h0000_BEEF); cyc(0, 1, 16'h8, 0);
    curReq = "R4"; cyc(0, 1, 16'hC, 0);
    swIn = 8'h3C; cyc(0, 1, 16'hC, 0); cyc(0, 1, 16'hC, 0);
    cyc(0, 1, 16'hC, 0); cyc(0, 1, 16'hC, 0);
    swIn = 8'hC3; idle(3); cyc(0, 1, 16'hC, 0);
    curReq = "R5"; cyc(1, 0, 16'hC, 32'h0000_00FF); cyc(0, 1, 16'hC, 0);
    curReq = "R6"; cyc(1, 0, 16'h10, 32'h0000_DEAD); idle(1);
    cyc(1, 0, 16'h10, 32'h0000_DEAE); cyc(1, 0, 16'h10, 32'h0001_DEAD);
    cyc(1, 1, 16'h10, 32'h0000_DEAD); cyc(1, 0, 16'h10, 32'h0000_DEAD); idle(2);
    curReq = "R7"; cyc(0, 1, 16'h10, 0); cyc(0, 1, 16'h20, 0);
    cyc(0, 1, 16'h9, 0); cyc(0, 1, 16'h2, 0); cyc(0, 1, 16'hFFFC, 0);
    cyc(1, 0, 16'h9, 32'hAAAA_5555); cyc(1, 0, 16'hA, 32'h1111_2222);
    cyc(1, 0, 16'h20, 32'h3333_4444); cyc(1, 0, 16'h12, 32'h0000_DEAD);
    cyc(0, 1, 16'h8, 0);
    curReq = "R9"; idle(2);
    curReq = "R8"; @(negedge clk); #1 rstN = 1'b0; idle(2);
    #1 rstN = 1'b1; idle(2);
    curReq = "R3"; cyc(0, 1, 16'h8, 0); idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule